// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates eight interrupt sources for an 8-bit CPU core. Four sources come from active-low external pins, two from timer overflow pulses, one from a serial port (receive or transmit flag) and one from a third timer (overflow or external flag). Software writes a per-source enable mask, a global enable, two priority bit planes that give each source one of four levels, and a per-pin choice between level and falling-edge sensing. These writes use a small select/data write port.

The controller picks the pending, enabled source with the highest level. Among sources at that level, the lowest source index wins. The controller raises a request to the CPU only when the winner's level is strictly above every level currently being serviced, and it presents an 8-bit vector address. When the CPU acknowledges, the controller marks that level as in service. It also clears the source's flag when the source is an edge-sensed pin or one of the first two timers. A return-from-interrupt pulse retires the highest level in service, so nested handlers unwind in order.

Source indices, which also set the polling order: 0 ext pin 0, 1 timer A, 2 ext pin 1, 3 timer B, 4 serial, 5 timer C, 6 ext pin 2, 7 ext pin 3.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irqReq is 0 and inService is 0. All configuration fields reset to 0: every source is disabled, every level is 0 and every pin is level-sensed.
- R2: A source takes part in arbitration only if its bit i in the enable mask (cfgSel=0, cfgData[i]) is 1 and the global enable (cfgSel=3, cfgData[7]) is 1.
- R3: The level of source i is {prioHi[i], prioLo[i]}. prioLo is written through cfgSel=1 and prioHi through cfgSel=2, with bit i belonging to source i. A pending source at a higher level wins over any source at a lower level, whatever their indices.
- R4: Among pending sources at the winning level, the lowest source index wins, using the index order given above.
- R5: irqVector equals 8*index+3 of the presented source (0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B, 0x33, 0x3B).
- R6: irqReq is asserted only when the winning level is strictly greater than the highest level set in inService, or when inService is 0. The output is registered and follows a change of the pending state by one cycle.
- R7: When ack is sampled high while irqReq is high, irqReq is 0 in the next cycle and the inService bit of the presented source's level is set (bit n for level n).
- R8: A reti pulse clears the highest set bit of inService.
- R9: External pin e is active low. Its sense bit (cfgSel=3, cfgData[e]) selects level sensing (0) or falling-edge sensing (1). Each pin passes through a two-flop synchronizer, so a pin change reaches irqReq 3 cycles later in level mode and 4 cycles later in edge mode.
- R10: On acknowledge, the flag of an edge-sensed pin and the flags of timers A and B (set by tmrOvfPulse[0] and tmrOvfPulse[1]) are cleared. A level-sensed pin request is not cleared.
- R11: The serial request (serRx | serTx) and the timer C request (tmr2Ovf | tmr2Ext) are never cleared by the controller. They request again after reti as long as their inputs stay high.
- R12: While irqReq is high and ack is low, irqVector does not change, even if a different source would now win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | 0 enable mask, 1 prioLo, 2 prioHi, 3 {global enable bit 7, pin sense bits 3:0} |
| cfgData | input | 8 | Configuration write data |
| extPinN | input | 4 | Active-low external request pins 0..3 |
| tmrOvfPulse | input | 2 | Overflow pulses of timers A (bit 0) and B (bit 1) |
| serRx | input | 1 | Serial receive flag |
| serTx | input | 1 | Serial transmit flag |
| tmr2Ovf | input | 1 | Timer C overflow flag |
| tmr2Ext | input | 1 | Timer C external flag |
| ack | input | 1 | CPU vectoring acknowledge |
| reti | input | 1 | Return-from-interrupt pulse |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVector | output | 8 | Vector address of the presented source |
| inService | output | 4 | One bit per priority level currently in service |

## Verification
The bench drives every input just after a rising edge and counts rising edges. Each expectation is queued with the cycle number it is due in, so that a monitor can compare it at the falling edge of exactly that cycle.

The due cycles are fixed by the block's timing:
- Configuration writes and serial or timer C level changes show on irqReq one cycle after they are applied.
- A timer pulse shows one cycle after its pulse cycle ends.
- Level-sensed and edge-sensed pins show 3 and 4 cycles after the pin changes.
- ack and reti change inService, and drop irqReq, in the very cycle that samples them. A request that reti unblocks follows one cycle later.

Checks placed one cycle before a pin is due confirm that the synchronizer latency is not shorter than specified.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 8;
  localparam int NUM_EXT = 4;
  localparam int NUM_LVL = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int VEC_W   = 8;
  localparam int CFG_W   = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] ackClr;  // one-hot source being vectored to
  } ctrlStrobe_t;

  // source index served by each external pin
  function automatic int extSrcIdx(input int e);
    case (e)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic [CFG_W-1:0]    cfgData,
  input  logic [NUM_EXT-1:0]  extPinN,
  input  logic [1:0]          tmrOvfPulse,
  input  logic                serRx,
  input  logic                serTx,
  input  logic                tmr2Ovf,
  input  logic                tmr2Ext,
  input  ctrlStrobe_t         strobe,
  output logic [NUM_SRC-1:0]  pendFlags,
  output logic [NUM_SRC-1:0]  enMask,
  output logic [NUM_SRC-1:0]  prioLo,
  output logic [NUM_SRC-1:0]  prioHi,
  output logic                globalEn
);
  logic [NUM_EXT-1:0] extEdge;
  logic [NUM_EXT-1:0] syncStage [SYNC_STAGES];
  logic [NUM_EXT-1:0] pinNow, pinPrev, pinFall;
  logic [NUM_EXT-1:0] edgeFlag, extReq;
  logic [1:0]         tmrFlag;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '0;
      prioLo   <= '0;
      prioHi   <= '0;
      extEdge  <= '0;
      globalEn <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfgSel)
        2'd0: enMask <= cfgData[NUM_SRC-1:0];
        2'd1: prioLo <= cfgData[NUM_SRC-1:0];
        2'd2: prioHi <= cfgData[NUM_SRC-1:0];
        default: begin
          extEdge  <= cfgData[NUM_EXT-1:0];
          globalEn <= cfgData[CFG_W-1];
        end
      endcase
    end
  end

  // pin synchronizer, idle level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncStage[k] <= '1;
      pinPrev <= '1;
    end else begin
      syncStage[0] <= extPinN;
      for (int k = 1; k < SYNC_STAGES; k++) syncStage[k] <= syncStage[k-1];
      pinPrev <= pinNow;
    end
  end

  assign pinNow  = syncStage[SYNC_STAGES-1];
  assign pinFall = pinPrev & ~pinNow;

  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      always_ff @(posedge clk) begin
        if (!rstN || !extEdge[e])      edgeFlag[e] <= 1'b0;
        else if (pinFall[e])           edgeFlag[e] <= 1'b1;
        else if (strobe.ackClr[extSrcIdx(e)]) edgeFlag[e] <= 1'b0;
      end
      assign extReq[e] = extEdge[e] ? edgeFlag[e] : ~pinNow[e];
    end
  endgenerate

  // timer A/B flags: set by overflow, cleared when vectored to
  always_ff @(posedge clk) begin
    if (!rstN) tmrFlag <= '0;
    else begin
      if (tmrOvfPulse[0])        tmrFlag[0] <= 1'b1;
      else if (strobe.ackClr[1]) tmrFlag[0] <= 1'b0;
      if (tmrOvfPulse[1])        tmrFlag[1] <= 1'b1;
      else if (strobe.ackClr[3]) tmrFlag[1] <= 1'b0;
    end
  end

  always_comb begin
    pendFlags    = '0;
    pendFlags[0] = extReq[0];
    pendFlags[1] = tmrFlag[0];
    pendFlags[2] = extReq[1];
    pendFlags[3] = tmrFlag[1];
    pendFlags[4] = serRx | serTx;
    pendFlags[5] = tmr2Ovf | tmr2Ext;
    pendFlags[6] = extReq[2];
    pendFlags[7] = extReq[3];
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendFlags,
  input  logic [NUM_SRC-1:0] enMask,
  input  logic [NUM_SRC-1:0] prioLo,
  input  logic [NUM_SRC-1:0] prioHi,
  input  logic               globalEn,
  input  logic               ack,
  input  logic               reti,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output logic [NUM_LVL-1:0] inService,
  output ctrlStrobe_t        strobe
);
  logic [NUM_SRC-1:0] eligible;
  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [NUM_LVL-1:0] lvlHit;
  logic [LVL_W-1:0]   winLvl, topLvl;
  logic [SRC_W-1:0]   winIdx;
  logic               found, anyInSvc, reqNow, ackOk;
  logic [NUM_LVL-1:0] retiMask;
  logic               reqQ;
  logic [SRC_W-1:0]   vecIdxQ;
  logic [LVL_W-1:0]   lvlQ;
  logic [NUM_LVL-1:0] inSvcQ;

  assign eligible = pendFlags & enMask & {NUM_SRC{globalEn}};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
      assign srcLvl[s] = {prioHi[s], prioLo[s]};
    end
  endgenerate

  // winner: highest level, then lowest index
  always_comb begin
    lvlHit = '0;
    winLvl = '0;
    winIdx = '0;
    found  = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (eligible[s]) lvlHit[srcLvl[s]] = 1'b1;
    for (int l = 0; l < NUM_LVL; l++)
      if (lvlHit[l]) begin
        winLvl = LVL_W'(l);
        found  = 1'b1;
      end
    for (int s = NUM_SRC - 1; s >= 0; s--)
      if (eligible[s] && srcLvl[s] == winLvl) winIdx = SRC_W'(s);
  end

  // highest level in service
  always_comb begin
    topLvl   = '0;
    anyInSvc = 1'b0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inSvcQ[l]) begin
        topLvl   = LVL_W'(l);
        anyInSvc = 1'b1;
      end
    retiMask = (reti && anyInSvc) ? (NUM_LVL'(1) << topLvl) : '0;
  end

  assign reqNow = found && (!anyInSvc || winLvl > topLvl);
  assign ackOk  = ack && reqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      vecIdxQ <= '0;
      lvlQ    <= '0;
      inSvcQ  <= '0;
    end else begin
      reqQ <= reqNow && !ackOk;
      if ((!reqQ || ackOk) && reqNow) begin
        vecIdxQ <= winIdx;
        lvlQ    <= winLvl;
      end
      inSvcQ <= (inSvcQ & ~retiMask) | (ackOk ? (NUM_LVL'(1) << lvlQ) : '0);
    end
  end

  always_comb begin
    strobe.ackClr = '0;
    if (ackOk) strobe.ackClr[vecIdxQ] = 1'b1;
  end

  assign irqReq    = reqQ;
  assign irqVector = {{(VEC_W-SRC_W-3){1'b0}}, vecIdxQ, 3'b011};
  assign inService = inSvcQ;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgSel,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NUM_EXT-1:0] extPinN,
  input  logic [1:0]         tmrOvfPulse,
  input  logic               serRx,
  input  logic               serTx,
  input  logic               tmr2Ovf,
  input  logic               tmr2Ext,
  input  logic               ack,
  input  logic               reti,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output logic [NUM_LVL-1:0] inService
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] pendFlags, enMask, prioLo, prioHi;
  logic               globalEn;

  irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .extPinN(extPinN), .tmrOvfPulse(tmrOvfPulse), .serRx(serRx), .serTx(serTx),
    .tmr2Ovf(tmr2Ovf), .tmr2Ext(tmr2Ext), .strobe(strobe), .pendFlags(pendFlags),
    .enMask(enMask), .prioLo(prioLo), .prioHi(prioHi), .globalEn(globalEn)
  );

  irq_control u_ctl (
    .clk(clk), .rstN(rstN), .pendFlags(pendFlags), .enMask(enMask), .prioLo(prioLo),
    .prioHi(prioHi), .globalEn(globalEn), .ack(ack), .reti(reti), .irqReq(irqReq),
    .irqVector(irqVector), .inService(inService), .strobe(strobe)
  );
endmodule

// File: rtl/irq_checker.sv
module irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [1:0] cfgSel,
  input logic [7:0] cfgData,
  input logic       ack,
  input logic       reti,
  input logic       irqReq,
  input logic [7:0] irqVector,
  input logic [3:0] inService
);
  // R7
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq) |=> !irqReq);

  // R7
  ack_sets_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqReq) |=> inService != 4'b0);

  // R8
  reti_retires_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reti && !ack && inService != 4'b0) |=>
      $countones(inService) == $countones($past(inService)) - 1);

  // R12
  vector_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !ack) |=> $stable(irqVector));

  // R5
  vector_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqVector[2:0] == 3'b011 && irqVector[7:6] == 2'b00);

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd3 && !cfgData[7]) |=> ##1 !irqReq);
endmodule

bind prio_irq_ctrl irq_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
  .ack(ack), .reti(reti), .irqReq(irqReq), .irqVector(irqVector), .inService(inService)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [7:0] cfgData = '0;
  logic [3:0] extPinN = 4'hF;
  logic [1:0] tmrOvfPulse = '0;
  logic       serRx = 1'b0, serTx = 1'b0, tmr2Ovf = 1'b0, tmr2Ext = 1'b0;
  logic       ack = 1'b0, reti = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;
  logic [3:0] inService;

  int cycleCnt = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int         due;
    logic       req;
    logic [7:0] vec;
    logic [3:0] isv;
    string      tag;
  } expItem_t;

  expItem_t sb[$];
  expItem_t item;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .extPinN(extPinN), .tmrOvfPulse(tmrOvfPulse), .serRx(serRx), .serTx(serTx),
    .tmr2Ovf(tmr2Ovf), .tmr2Ext(tmr2Ext), .ack(ack), .reti(reti),
    .irqReq(irqReq), .irqVector(irqVector), .inService(inService)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // monitor: pops due items at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cycleCnt) begin
      item = sb.pop_front();
      checks++;
      if (item.due != cycleCnt || irqReq !== item.req || inService !== item.isv ||
          (item.req && irqVector !== item.vec)) begin
        failures++;
        $display("FAIL %s: cycle %0d req=%0b vec=%02h isv=%04b, expected cycle %0d req=%0b vec=%02h isv=%04b",
                 item.tag, cycleCnt, irqReq, irqVector, inService,
                 item.due, item.req, item.vec, item.isv);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycleCnt > 20000 && !finished) begin
      failures++;
      $display("FAIL watchdog: cycle %0d, expected completion", cycleCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic expectAt(input int dly, input logic req, input logic [7:0] vec,
                          input logic [3:0] isv, input string tag);
    expItem_t e;
    e.due = cycleCnt + dly;
    e.req = req;
    e.vec = vec;
    e.isv = isv;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wrCfg(input logic [1:0] sel, input logic [7:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic doAck();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic doReti();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  task automatic pulseTmr(input int which);
    tmrOvfPulse[which] = 1'b1;
    step();
    tmrOvfPulse = '0;
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R1 reset state");
    waitCyc(2);

    // enables
    wrCfg(2'd0, 8'hFF);
    serRx = 1'b1;
    waitCyc(3);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R2 global enable off blocks");
    wrCfg(2'd3, 8'h80);
    expectAt(1, 1'b1, 8'h23, 4'b0000, "R2 R5 serial request");
    waitCyc(2);
    wrCfg(2'd0, 8'hEF);
    expectAt(1, 1'b0, 8'h00, 4'b0000, "R2 mask bit 4 blocks serial");
    waitCyc(2);
    wrCfg(2'd0, 8'hFF);
    expectAt(1, 1'b1, 8'h23, 4'b0000, "R2 mask restored");
    waitCyc(2);

    // acknowledge and nesting
    doAck();
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R7 ack marks level 0");
    waitCyc(3);
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R6 equal level waits");
    wrCfg(2'd2, 8'h08);
    pulseTmr(1);
    expectAt(1, 1'b1, 8'h1B, 4'b0001, "R3 R6 timer B level 2 preempts");
    waitCyc(2);
    doAck();
    expectAt(0, 1'b0, 8'h00, 4'b0101, "R7 ack marks level 2");
    waitCyc(2);
    doReti();
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R8 reti clears level 2");
    waitCyc(3);
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R10 timer flag cleared");
    doReti();
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R8 reti clears level 0");
    expectAt(1, 1'b1, 8'h23, 4'b0000, "R11 serial flag kept");
    waitCyc(2);
    doAck();
    serRx = 1'b0;
    doReti();
    wrCfg(2'd2, 8'h00);
    waitCyc(2);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R11 serial released");
    waitCyc(1);

    // polling order and vector hold
    tmr2Ovf = 1'b1;
    serTx = 1'b1;
    expectAt(1, 1'b1, 8'h23, 4'b0000, "R4 serial before timer C");
    waitCyc(2);
    serTx = 1'b0;
    waitCyc(3);
    expectAt(0, 1'b1, 8'h23, 4'b0000, "R12 vector held until ack");
    doAck();
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R7 ack serial");
    waitCyc(2);
    doReti();
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R8 reti");
    expectAt(1, 1'b1, 8'h2B, 4'b0000, "R4 R11 timer C next");
    waitCyc(2);
    doAck();
    tmr2Ovf = 1'b0;
    doReti();
    waitCyc(2);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R11 timer C released");
    waitCyc(1);

    // edge-sensed pin 0
    wrCfg(2'd3, 8'h81);
    extPinN[0] = 1'b0;
    expectAt(3, 1'b0, 8'h00, 4'b0000, "R9 edge not yet due");
    expectAt(4, 1'b1, 8'h03, 4'b0000, "R9 edge request after 4");
    waitCyc(5);
    extPinN[0] = 1'b1;
    doAck();
    expectAt(0, 1'b0, 8'h00, 4'b0001, "R7 ack edge pin");
    waitCyc(3);
    doReti();
    waitCyc(3);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R10 edge flag cleared");
    waitCyc(1);

    // level-sensed pin 1
    wrCfg(2'd3, 8'h80);
    extPinN[1] = 1'b0;
    expectAt(2, 1'b0, 8'h00, 4'b0000, "R9 level not yet due");
    expectAt(3, 1'b1, 8'h13, 4'b0000, "R9 level request after 3");
    waitCyc(4);
    doAck();
    waitCyc(2);
    doReti();
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R8 reti level pin");
    expectAt(1, 1'b1, 8'h13, 4'b0000, "R10 level flag not cleared");
    waitCyc(2);
    extPinN[1] = 1'b1;
    doAck();
    doReti();
    waitCyc(4);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R9 level pin released");
    waitCyc(1);

    // level beats polling order
    wrCfg(2'd1, 8'h80);
    wrCfg(2'd2, 8'h80);
    extPinN[0] = 1'b0;
    extPinN[3] = 1'b0;
    expectAt(3, 1'b1, 8'h3B, 4'b0000, "R3 level 3 pin 3 beats pin 0");
    waitCyc(4);
    doAck();
    expectAt(0, 1'b0, 8'h00, 4'b1000, "R7 ack marks level 3");
    waitCyc(3);
    expectAt(0, 1'b0, 8'h00, 4'b1000, "R6 lower level blocked");
    extPinN = 4'hF;
    doReti();
    waitCyc(4);
    expectAt(0, 1'b0, 8'h00, 4'b0000, "R8 all retired");
    waitCyc(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule